// File: doc/BRIEF.md
# Two-Wire Converter Readout Slave

This block is the serial front end of a three-channel, 10-bit acquisition unit. It watches a two-wire bus made of a clock line and an open-drain data line, decodes an 8-bit command byte, and on a conversion-read command it acknowledges, asks an external conversion core for a sample on the selected channel, and returns the 10-bit result to the host in two bytes. The conversion core sits behind a simple request/done/data handshake. The analog front end, the nonvolatile limit storage and the alert logic are outside this block.

The host picks one of three behaviours once the data has been returned. A STOP ends the transaction and puts the block into standby. A host ACK after the low data byte, followed by more clocks, starts another conversion on the same channel. When the channel field holds the sweep code, each further conversion moves to the next channel in a 0, 1, 2, 0 ... cycle. Each first byte echoes the channel that was actually converted, so the host can tell the samples of a sweep apart.

Top module: `twi_cvt_slave`

## Requirements
- R1: The command byte arrives MSB first as bits [7:4] device identifier (default 4'b1001), bit 3 storage/convert select, bits [2:1] channel code, bit 0 read/monitor. With a matching identifier, bit 3 = 0 and bit 0 = 1, the slave drives SDA low for the ninth clock and pulses `conv_req` with `conv_chan` set to the selected channel.
- R2: With a non-matching identifier the slave gives no ACK, issues no conversion request and leaves SDA released until the next START.
- R3: With a matching identifier, bit 3 = 0 and bit 0 = 0 (monitor enable), the slave acknowledges but requests no conversion and returns no data. With bit 3 = 1 it gives no ACK and stays off the bus.
- R4: The first returned byte is 4'b0000, then the two channel bits, then result bits 9 and 8; the second is result bits 7 to 0; both are sent MSB first.
- R5: A host ACK (SDA low) after the second data byte starts another conversion request on the same channel, and the next two bytes carry that new result.
- R6: Channel code 3 selects the sweep: the first conversion uses channel 0 and each following one advances 0, 1, 2, 0, ...; the echoed channel and `conv_chan` equal the channel converted.
- R7: A host NACK (SDA high) after any data byte makes the slave release SDA and request nothing more; a STOP sets `standby` high and a START clears it.
- R8: If a conversion has not completed when the first bit of a result is due, the slave returns the most recently completed result of that channel (zero after reset).
- R9: The slave samples SDA on rising SCL and changes its SDA drive only while SCL is low; START and STOP are SDA falling and rising edges while SCL is high.
- R10: After reset `sda_low` is 0, `conv_req` is 0 and `standby` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_low | output | 1 | 1 pulls the data line low, 0 releases it |
| standby | output | 1 | High while the block is idle after reset or a STOP |
| conv_req | output | 1 | One-cycle request for a conversion |
| conv_chan | output | 2 | Channel of the requested conversion |
| conv_done | input | 1 | One-cycle pulse from the core when a result is ready |
| conv_data | input | 10 | Result qualified by `conv_done` |

## Verification
The bench builds the block with its defaults: identifier 4'b1001, three channels and a 10-bit result, so the sweep code 3 is the only code beyond the last channel and a four-conversion sweep reaches the wrap from channel 2 back to 0. The converter model's latency is a bench variable: a short value makes every result fresh, and a latency longer than a whole transaction exposes the stale-result path of R8 against the value the model last delivered for that channel.

// File: rtl/twi_cvt_pkg.sv
`timescale 1ns/1ps
package twi_cvt_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 4;
  localparam int CH_W   = 2;
  localparam int RES_W  = 10;
  localparam int HI_W   = RES_W - BYTE_W;
  localparam int PAD_W  = BYTE_W - CH_W - HI_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_AHOLD,
    ST_TX,
    ST_MWAIT,
    ST_MACK,
    ST_MNEXT,
    ST_IGNORE
  } rd_state_e;
endpackage

// File: rtl/twi_line_cond.sv
`timescale 1ns/1ps
module twi_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int SYNC_D = 3;

  logic [SYNC_D-1:0] scl_sr_q, scl_sr_d;
  logic [SYNC_D-1:0] sda_sr_q, sda_sr_d;

  always_comb begin
    scl_sr_d = {scl_sr_q[SYNC_D-2:0], scl_in};
    sda_sr_d = {sda_sr_q[SYNC_D-2:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr_q <= '1;
      sda_sr_q <= '1;
    end else begin
      scl_sr_q <= scl_sr_d;
      sda_sr_q <= sda_sr_d;
    end
  end

  assign scl_hi   = scl_sr_q[SYNC_D-2];
  assign sda_hi   = sda_sr_q[SYNC_D-2];
  assign scl_rise = scl_sr_q[SYNC_D-2] & ~scl_sr_q[SYNC_D-1];
  assign scl_fall = ~scl_sr_q[SYNC_D-2] & scl_sr_q[SYNC_D-1];
  assign start_ev = scl_sr_q[SYNC_D-2] & scl_sr_q[SYNC_D-1] &
                    sda_sr_q[SYNC_D-1] & ~sda_sr_q[SYNC_D-2];
  assign stop_ev  = scl_sr_q[SYNC_D-2] & scl_sr_q[SYNC_D-1] &
                    ~sda_sr_q[SYNC_D-1] & sda_sr_q[SYNC_D-2];
endmodule

// File: rtl/twi_conv_seq.sv
`timescale 1ns/1ps
module twi_conv_seq import twi_cvt_pkg::*; #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_go,
  input  logic [CH_W-1:0]   sel_code,
  input  logic              next_go,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  output logic [CH_W-1:0]   cur_chan,
  output logic [RES_W-1:0]  cur_result
);
  localparam logic [CH_W-1:0] AUTO_CODE = {CH_W{1'b1}};
  localparam logic [CH_W-1:0] LAST_CH   = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] chan_q, chan_d;
  logic            auto_q, auto_d;
  logic            req_q, req_d;
  logic [NUM_CH*RES_W-1:0] slot_flat;

  always_comb begin
    chan_d = chan_q;
    auto_d = auto_q;
    req_d  = 1'b0;
    if (first_go) begin
      auto_d = (sel_code == AUTO_CODE);
      chan_d = auto_d ? '0 : sel_code;
      req_d  = 1'b1;
    end else if (next_go) begin
      if (auto_q) begin
        chan_d = (chan_q == LAST_CH) ? '0 : chan_q + 1'b1;
      end
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      auto_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      chan_q <= chan_d;
      auto_q <= auto_d;
      req_q  <= req_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [RES_W-1:0] val_q;
    logic             load;
    assign load = conv_done && (chan_q == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (load) begin
        val_q <= conv_data;
      end
    end
    assign slot_flat[g*RES_W +: RES_W] = val_q;
  end

  always_comb begin
    cur_result = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_q == CH_W'(i)) cur_result = slot_flat[i*RES_W +: RES_W];
    end
  end

  assign conv_req  = req_q;
  assign conv_chan = chan_q;
  assign cur_chan  = chan_q;

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R6
  req_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_chan <= LAST_CH));
endmodule

// File: rtl/twi_cvt_slave.sv
`timescale 1ns/1ps
module twi_cvt_slave import twi_cvt_pkg::*; #(
  parameter logic [ID_W-1:0] DEV_ID = 4'b1001,
  parameter int              NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_low,
  output logic              standby,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_hi, sda_hi, scl_rise, scl_fall, start_ev, stop_ev;

  twi_line_cond u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_hi   (scl_hi),
    .sda_hi   (sda_hi),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  rd_state_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [BYTE_W-1:0]  lo_q, lo_d;
  logic               drv_q, drv_d;
  logic               rd_q, rd_d;
  logic               bsel_q, bsel_d;
  logic               first_go, next_go, load_first;
  logic [CH_W-1:0]    cur_chan;
  logic [RES_W-1:0]   cur_result;
  logic               id_ok;

  twi_conv_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_go   (first_go),
    .sel_code   (sh_q[CH_W:1]),
    .next_go    (next_go),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .conv_req   (conv_req),
    .conv_chan  (conv_chan),
    .cur_chan   (cur_chan),
    .cur_result (cur_result)
  );

  assign id_ok = (sh_q[BYTE_W-1 -: ID_W] == DEV_ID);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    lo_d       = lo_q;
    drv_d      = drv_q;
    rd_d       = rd_q;
    bsel_d     = bsel_q;
    first_go   = 1'b0;
    next_go    = 1'b0;
    load_first = 1'b0;
    if (stop_ev) begin
      st_d  = ST_IDLE;
      drv_d = 1'b0;
    end else if (start_ev) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      drv_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_hi};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) st_d = ST_AACK;
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (id_ok && !sh_q[CH_W+1]) begin
              drv_d    = 1'b1;
              rd_d     = sh_q[0];
              first_go = sh_q[0];
              st_d     = ST_AHOLD;
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        ST_AHOLD: begin
          if (scl_fall) begin
            if (rd_q) begin
              load_first = 1'b1;
            end else begin
              drv_d = 1'b0;
              st_d  = ST_IGNORE;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) st_d = ST_MWAIT;
          end else if (scl_fall) begin
            sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
            drv_d = ~sh_q[BYTE_W-2];
          end
        end
        ST_MWAIT: begin
          if (scl_fall) begin
            drv_d = 1'b0;
            st_d  = ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (!sda_hi) begin
              next_go = bsel_q;
              st_d    = ST_MNEXT;
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        ST_MNEXT: begin
          if (scl_fall) begin
            if (!bsel_q) begin
              sh_d   = lo_q;
              drv_d  = ~lo_q[BYTE_W-1];
              bsel_d = 1'b1;
              cnt_d  = '0;
              st_d   = ST_TX;
            end else begin
              load_first = 1'b1;
            end
          end
        end
        default: begin
          drv_d = 1'b0;
        end
      endcase
      if (load_first) begin
        sh_d   = {{PAD_W{1'b0}}, cur_chan, cur_result[RES_W-1 -: HI_W]};
        lo_d   = cur_result[BYTE_W-1:0];
        drv_d  = 1'b1;
        bsel_d = 1'b0;
        cnt_d  = '0;
        st_d   = ST_TX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      lo_q   <= '0;
      drv_q  <= 1'b0;
      rd_q   <= 1'b0;
      bsel_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      lo_q   <= lo_d;
      drv_q  <= drv_d;
      rd_q   <= rd_d;
      bsel_q <= bsel_d;
    end
  end

  assign sda_low = drv_q;
  assign standby = (st_q == ST_IDLE);

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !scl_hi);

  // R7
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !sda_low);

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE) |-> !sda_low);

  // R1
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> (st_q == ST_AHOLD || st_q == ST_TX));
endmodule

// File: tb/twi_cvt_slave_tb_top.sv
`timescale 1ns/1ps
module twi_cvt_slave_tb_top;
  localparam int HP = 20;

  typedef struct packed {
    logic [7:0] addr;
    logic       exp_ack;
    logic [2:0] n_conv;
    logic       sweep;
    logic [1:0] ch;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'b1001_0_01_1, 1'b1, 3'd2, 1'b0, 2'd1},
    '{8'b1001_0_10_1, 1'b1, 3'd1, 1'b0, 2'd2},
    '{8'b1001_0_00_1, 1'b1, 3'd3, 1'b0, 2'd0},
    '{8'b1001_0_11_1, 1'b1, 3'd4, 1'b1, 2'd0},
    '{8'b0110_0_01_1, 1'b0, 3'd0, 1'b0, 2'd0},
    '{8'b1001_0_01_0, 1'b1, 3'd0, 1'b0, 2'd0},
    '{8'b1001_1_01_1, 1'b0, 3'd0, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic scl;
  logic host_low;
  logic sda_line;
  logic sda_low, standby, conv_req, conv_done;
  logic [1:0] conv_chan;
  logic [9:0] conv_data;

  always #10 clk = ~clk;
  assign sda_line = ~(host_low | sda_low);

  twi_cvt_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (sda_line),
    .sda_low   (sda_low),
    .standby   (standby),
    .conv_req  (conv_req),
    .conv_chan (conv_chan),
    .conv_done (conv_done),
    .conv_data (conv_data)
  );

  int tests = 0;
  int fails = 0;
  int lat = 5;
  int req_cnt;
  logic [1:0] req_log [256];
  logic       pend;
  int         cdown;
  logic [1:0] pch;
  int         seq;
  logic [9:0] last_done [3];

  function automatic logic [9:0] mk_val(input logic [1:0] c, input int s);
    return 10'((int'(c) * 341 + s * 37 + 5) % 1024);
  endfunction

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) begin
      pend    <= 1'b0;
      seq     <= 0;
      req_cnt <= 0;
      cdown   <= 0;
      pch     <= 2'd0;
      conv_data <= '0;
      for (int i = 0; i < 3; i++) last_done[i] <= '0;
    end else begin
      if (conv_req) begin
        req_log[req_cnt[7:0]] <= conv_chan;
        req_cnt <= req_cnt + 1;
        if (!pend) begin
          pend  <= 1'b1;
          cdown <= lat;
          pch   <= conv_chan;
        end
      end else if (pend) begin
        if (cdown <= 1) begin
          pend      <= 1'b0;
          conv_done <= 1'b1;
          conv_data <= mk_val(pch, seq);
          last_done[pch] <= mk_val(pch, seq);
          seq <= seq + 1;
        end else begin
          cdown <= cdown - 1;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    wt(HP/2);
    host_low = ~b;
    wt(HP/2);
    scl = 1'b1;
    wt(HP/2);
    r = sda_line;
    wt(HP/2);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    host_low = 1'b0;
    wt(HP);
    scl = 1'b1;
    wt(HP);
    host_low = 1'b1;
    wt(HP);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(HP/2);
    host_low = 1'b1;
    wt(HP);
    scl = 1'b1;
    wt(HP);
    host_low = 1'b0;
    wt(HP);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
  endtask

  task automatic run_vec(input vec_t v, input string tg);
    logic r;
    logic [7:0] b;
    logic [8:0] idle_bits;
    int base;
    logic [1:0] ech;
    logic [9:0] ev;
    base = req_cnt;
    bus_start();
    wt(4);
    chk({tg, " R7 START clears standby"}, int'(standby), 0);
    for (int i = 7; i >= 0; i--) clk_bit(v.addr[i], r);
    clk_bit(1'b1, r);
    chk({tg, " R1/R2/R3 ack slot"}, int'(r), v.exp_ack ? 0 : 1);
    if (v.n_conv == 0) begin
      for (int i = 0; i < 9; i++) begin
        clk_bit(1'b1, r);
        idle_bits[i] = r;
      end
      chk({tg, " R2/R3 line stays released"}, int'(idle_bits), 9'h1ff);
      chk({tg, " R2/R3 no conversion request"}, req_cnt - base, 0);
    end else begin
      for (int k = 0; k < int'(v.n_conv); k++) begin
        ech = v.sweep ? 2'(k % 3) : v.ch;
        ev  = last_done[ech];
        rd_byte(b);
        chk({tg, " R4 first byte"}, int'(b), int'({4'b0000, ech, ev[9:8]}));
        chk({tg, " R6 requested channel"}, int'(req_log[8'(base + k)]), int'(ech));
        clk_bit(1'b0, r);
        rd_byte(b);
        chk({tg, " R4 second byte"}, int'(b), int'(ev[7:0]));
        clk_bit((k == int'(v.n_conv) - 1), r);
      end
      chk({tg, " R5 request count"}, req_cnt - base, int'(v.n_conv));
    end
    bus_stop();
    chk({tg, " R7 STOP sets standby"}, int'(standby), 1);
    chk({tg, " R7 line released"}, int'(sda_low), 0);
  endtask

  initial begin
    logic r;
    logic [7:0] b;
    logic [8:0] idle_bits;
    logic [9:0] old2;
    int base;
    scl = 1'b1;
    host_low = 1'b0;
    rst_n = 1'b0;
    wt(10);
    chk("R10 reset sda_low", int'(sda_low), 0);
    chk("R10 reset conv_req", int'(conv_req), 0);
    chk("R10 reset standby", int'(standby), 1);
    rst_n = 1'b1;
    wt(10);
    chk("R10 standby after release", int'(standby), 1);

    // R8: busy before any completion returns the reset value of the slot
    lat = 3000;
    run_vec(VECS[1], "R8 reset-slot");
    wt(3200);
    lat = 5;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R8: stale result when the converter is still busy
    old2 = last_done[2];
    lat = 3000;
    base = req_cnt;
    bus_start();
    for (int i = 7; i >= 0; i--) clk_bit(VECS[1].addr[i], r);
    clk_bit(1'b1, r);
    chk("R8 ack", int'(r), 0);
    rd_byte(b);
    chk("R8 stale first byte", int'(b), int'({4'b0000, 2'd2, old2[9:8]}));
    clk_bit(1'b0, r);
    rd_byte(b);
    chk("R8 stale second byte", int'(b), int'(old2[7:0]));
    clk_bit(1'b1, r);
    bus_stop();
    chk("R8 one request", req_cnt - base, 1);
    wt(3200);
    lat = 5;
    run_vec(VECS[1], "R8 fresh");

    // R7: NACK after the first byte stops the readout
    base = req_cnt;
    bus_start();
    for (int i = 7; i >= 0; i--) clk_bit(VECS[0].addr[i], r);
    clk_bit(1'b1, r);
    chk("R7 ack", int'(r), 0);
    rd_byte(b);
    clk_bit(1'b1, r);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, r);
      idle_bits[i] = r;
    end
    chk("R7 released after NACK", int'(idle_bits), 9'h1ff);
    chk("R7 no request after NACK", req_cnt - base, 1);
    bus_stop();
    chk("R7 standby after STOP", int'(standby), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule